// File: doc/BRIEF.md
# Interrupt-Generation Register Write Access Checker

This block decides, for each write that software makes to the system register that raises software-generated interrupts, what the write should do. Three outcomes are possible. The write may be refused as an undefined instruction. It may be trapped to a higher exception level, with a fixed syndrome class. Or it may be allowed to update the register.

The decision depends on several inputs: the exception level the write comes from, the feature-present flags, and the register-interface enables for levels 1 to 3. It also depends on the hypervisor trap controls, on the top-level IRQ/FIQ routing bits, and on two policy flags that turn a level-3 trap into an undefined result.

Each level has its own chain of checks, and the checks in a chain are taken in a fixed priority order. The decision is registered, so it appears one clock after the request. The register contents and the exception entry itself are handled elsewhere.

Top module: `sreg_access_resolver`

## Requirements
- R1: When either feature-present flag is 0, or when the current level is 0, the result is undefined.
- R2: At level 1 the checks are taken in this order, and the first one that matches decides the result:
  - routing both set with level 3 present and the early policy set gives undefined;
  - the level-1 interface enable at 0 traps to level 1;
  - level 2 enabled together with any of the three hypervisor trap bits traps to level 2.
- R3: At level 1, if none of the R2 checks match, the routing check applies. Routing both set with level 3 present gives undefined when the late policy is set, and traps to level 3 when it is clear. Otherwise the write is performed.
- R4: At level 2 the checks are, in order:
  - the early undefined check;
  - the level-2 interface enable at 0, which traps to level 2;
  - the routing check of R3;
  - otherwise the write is performed.
  The level-1 enable and the hypervisor trap bits have no effect at level 2.
- R5: At level 3, the level-3 interface enable at 0 traps to level 3; otherwise the write is performed. The routing bits, the policies and the lower enables have no effect at level 3.
- R6: On a trap, `syn_class` is 0x18. Without a trap, both `syn_class` and `trap_lvl` read 0. `trap_lvl` encodes the target level as a binary value on 2 bits.
- R7: On each evaluated request exactly one of `is_undef`, `is_trap` and `wr_en` is 1. All three are 0 when no request was presented.
- R8: The target level of a trap is never lower than the level of the request.
- R9: The result appears on the first rising edge after the request. It is registered, and a synchronous active-low reset clears it, even if a request is present during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A write is presented this cycle |
| cur_lvl | input | 2 | Exception level of the write, 0 to 3 |
| feat_ic | input | 1 | Interrupt-controller system interface present |
| feat_wide | input | 1 | 64-bit execution state present |
| ifc_en_l1 | input | 1 | Register interface enabled for level 1 |
| ifc_en_l2 | input | 1 | Register interface enabled for level 2 |
| ifc_en_l3 | input | 1 | Register interface enabled for level 3 |
| l2_active | input | 1 | Level 2 enabled in the current state |
| hyp_trap_all | input | 1 | Hypervisor common trap of interface accesses |
| hyp_fiq_ovr | input | 1 | Hypervisor FIQ override |
| hyp_irq_ovr | input | 1 | Hypervisor IRQ override |
| top_route_irq | input | 1 | IRQ routed to level 3 |
| top_route_fiq | input | 1 | FIQ routed to level 3 |
| l3_present | input | 1 | Level 3 implemented |
| pol_undef_early | input | 1 | Undefined takes priority over all traps on the routing check |
| pol_undef_late | input | 1 | Undefined replaces the level-3 routing trap |
| is_undef | output | 1 | Write is an undefined instruction |
| is_trap | output | 1 | Write traps |
| trap_lvl | output | 2 | Target level of the trap |
| syn_class | output | 6 | Syndrome class of the trap |
| wr_en | output | 1 | Write is performed |

## Verification
Every result is due exactly one rising edge after its request. The bench drives each request at a falling edge and compares all five outputs at the next falling edge, which lies half a period after the edge that registered the result. Because of this, back-to-back vectors each meet their own result and never a neighbour's. The idle check samples at the first falling edge after `req_valid` drops. The reset checks sample after an edge at which `rst_n` was low, while a trapping request is held on the inputs.

// File: rtl/sar_pkg.sv
// Shared types of the access resolver: level code, verdict, decision and
// the pre-decoded condition bundle used by every per-level chain.
package sar_pkg;
    localparam int LVL_W   = 2;
    localparam int NUM_LVL = 3;   // levels 1..3 have their own chain

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [1:0] {
        V_NONE  = 2'd0,
        V_UNDEF = 2'd1,
        V_TRAP  = 2'd2,
        V_DO    = 2'd3
    } verdict_e;

    typedef struct packed {
        verdict_e verdict;
        lvl_t     target;
    } decision_t;

    typedef struct packed {
        logic early_undef;  // routing hit with early policy
        logic route_hit;    // level 3 present and both routing bits set
        logic late_undef;   // late policy set
        logic hyp_trap;     // a hypervisor trap bit active under level 2
        logic en_l1;
        logic en_l2;
        logic en_l3;
    } cond_t;
endpackage

// File: rtl/sar_cond_decode.sv
// Condition decoder: reduces the raw control bits into the shared
// predicates that the level chains test. Purely combinational.
// Assumes the inputs are stable for the cycle in which a request is given.
module sar_cond_decode
    import sar_pkg::*;
(
    input  logic  ifc_en_l1,
    input  logic  ifc_en_l2,
    input  logic  ifc_en_l3,
    input  logic  l2_active,
    input  logic  hyp_trap_all,
    input  logic  hyp_fiq_ovr,
    input  logic  hyp_irq_ovr,
    input  logic  top_route_irq,
    input  logic  top_route_fiq,
    input  logic  l3_present,
    input  logic  pol_undef_early,
    input  logic  pol_undef_late,
    output cond_t cond
);
    logic route_both;

    // Routing check: both interrupt kinds taken to level 3, which exists.
    always_comb route_both = l3_present & top_route_irq & top_route_fiq;

    // Assemble the predicate bundle. The three hypervisor traps share one
    // target, so their relative order does not change the outcome.
    always_comb begin
        cond.early_undef = route_both & pol_undef_early;
        cond.route_hit   = route_both;
        cond.late_undef  = pol_undef_late;
        cond.hyp_trap    = l2_active & (hyp_trap_all | hyp_fiq_ovr | hyp_irq_ovr);
        cond.en_l1       = ifc_en_l1;
        cond.en_l2       = ifc_en_l2;
        cond.en_l3       = ifc_en_l3;
    end
endmodule

// File: rtl/sar_level_chain.sv
// One priority chain for a given source level (parameter LEVEL, 1..3).
// Each variant is chosen at elaboration; the first matching check decides.
// Assumes cond is the decoded bundle of the current cycle.
module sar_level_chain
    import sar_pkg::*;
#(
    parameter int unsigned LEVEL = 1
) (
    input  cond_t     cond,
    output decision_t dec
);
    localparam lvl_t L1 = lvl_t'(1);
    localparam lvl_t L2 = lvl_t'(2);
    localparam lvl_t L3 = lvl_t'(3);

    generate
        if (LEVEL == 1) begin : g_l1
            // Level 1: early undef, own enable, hypervisor, routing, perform.
            always_comb begin
                dec = '{verdict: V_DO, target: '0};
                if (cond.early_undef)      dec = '{verdict: V_UNDEF, target: '0};
                else if (!cond.en_l1)      dec = '{verdict: V_TRAP,  target: L1};
                else if (cond.hyp_trap)    dec = '{verdict: V_TRAP,  target: L2};
                else if (cond.route_hit)
                    dec = cond.late_undef ? '{verdict: V_UNDEF, target: '0}
                                          : '{verdict: V_TRAP,  target: L3};
            end
        end else if (LEVEL == 2) begin : g_l2
            // Level 2: early undef, own enable, routing, perform.
            always_comb begin
                dec = '{verdict: V_DO, target: '0};
                if (cond.early_undef)      dec = '{verdict: V_UNDEF, target: '0};
                else if (!cond.en_l2)      dec = '{verdict: V_TRAP,  target: L2};
                else if (cond.route_hit)
                    dec = cond.late_undef ? '{verdict: V_UNDEF, target: '0}
                                          : '{verdict: V_TRAP,  target: L3};
            end
        end else begin : g_l3
            // Level 3: own enable only.
            always_comb begin
                if (!cond.en_l3) dec = '{verdict: V_TRAP, target: L3};
                else             dec = '{verdict: V_DO,   target: '0};
            end
        end
    endgenerate
endmodule

// File: rtl/sar_result_reg.sv
// Result register: turns the selected decision into one-hot flags plus
// target level and syndrome, one cycle after the request.
// Assumes dec is V_NONE whenever no request is present.
module sar_result_reg
    import sar_pkg::*;
#(
    parameter int unsigned       SYND_W     = 6,
    parameter logic [SYND_W-1:0] SYND_CLASS = SYND_W'(8'h18)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  decision_t         dec,
    output logic              is_undef,
    output logic              is_trap,
    output lvl_t              trap_lvl,
    output logic [SYND_W-1:0] syn_class,
    output logic              wr_en
);
    // Register the decoded result; synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_undef  <= 1'b0;
            is_trap   <= 1'b0;
            trap_lvl  <= '0;
            syn_class <= '0;
            wr_en     <= 1'b0;
        end else begin
            is_undef  <= (dec.verdict == V_UNDEF);
            is_trap   <= (dec.verdict == V_TRAP);
            trap_lvl  <= (dec.verdict == V_TRAP) ? dec.target : '0;
            syn_class <= (dec.verdict == V_TRAP) ? SYND_CLASS : '0;
            wr_en     <= (dec.verdict == V_DO);
        end
    end
endmodule

// File: rtl/sreg_access_resolver.sv
// Top of the access resolver for writes to the interrupt-generation
// system register. Applies the global undefined checks, picks the chain of
// the current level and registers the outcome (latency one cycle).
// Assumes all control inputs are valid in the cycle req_valid is high.
module sreg_access_resolver
    import sar_pkg::*;
#(
    parameter int unsigned       SYND_W     = 6,
    parameter logic [SYND_W-1:0] SYND_CLASS = SYND_W'(8'h18)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        cur_lvl,
    input  logic              feat_ic,
    input  logic              feat_wide,
    input  logic              ifc_en_l1,
    input  logic              ifc_en_l2,
    input  logic              ifc_en_l3,
    input  logic              l2_active,
    input  logic              hyp_trap_all,
    input  logic              hyp_fiq_ovr,
    input  logic              hyp_irq_ovr,
    input  logic              top_route_irq,
    input  logic              top_route_fiq,
    input  logic              l3_present,
    input  logic              pol_undef_early,
    input  logic              pol_undef_late,
    output logic              is_undef,
    output logic              is_trap,
    output logic [1:0]        trap_lvl,
    output logic [SYND_W-1:0] syn_class,
    output logic              wr_en
);
    cond_t     cond;
    decision_t chain_dec [NUM_LVL];
    decision_t sel_dec;

    sar_cond_decode u_cond (
        .ifc_en_l1       (ifc_en_l1),
        .ifc_en_l2       (ifc_en_l2),
        .ifc_en_l3       (ifc_en_l3),
        .l2_active       (l2_active),
        .hyp_trap_all    (hyp_trap_all),
        .hyp_fiq_ovr     (hyp_fiq_ovr),
        .hyp_irq_ovr     (hyp_irq_ovr),
        .top_route_irq   (top_route_irq),
        .top_route_fiq   (top_route_fiq),
        .l3_present      (l3_present),
        .pol_undef_early (pol_undef_early),
        .pol_undef_late  (pol_undef_late),
        .cond            (cond)
    );

    generate
        for (genvar g = 0; g < NUM_LVL; g++) begin : g_chain
            sar_level_chain #(.LEVEL(g + 1)) u_chain (
                .cond (cond),
                .dec  (chain_dec[g])
            );
        end
    endgenerate

    // Global gate, then the chain belonging to the requesting level.
    always_comb begin
        sel_dec = '{verdict: V_NONE, target: '0};
        if (req_valid) begin
            if (!(feat_ic && feat_wide)) sel_dec = '{verdict: V_UNDEF, target: '0};
            else begin
                case (cur_lvl)
                    2'd1:    sel_dec = chain_dec[0];
                    2'd2:    sel_dec = chain_dec[1];
                    2'd3:    sel_dec = chain_dec[2];
                    default: sel_dec = '{verdict: V_UNDEF, target: '0};
                endcase
            end
        end
    end

    sar_result_reg #(.SYND_W(SYND_W), .SYND_CLASS(SYND_CLASS)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec       (sel_dec),
        .is_undef  (is_undef),
        .is_trap   (is_trap),
        .trap_lvl  (trap_lvl),
        .syn_class (syn_class),
        .wr_en     (wr_en)
    );

    // R7
    result_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({is_undef, is_trap, wr_en}));

    // R9
    result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_undef | is_trap | wr_en) == $past(req_valid & rst_n));

    // R1
    global_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n & req_valid & ((cur_lvl == 2'd0) | ~(feat_ic & feat_wide)))
        |-> is_undef);

    // R5
    top_level_defined_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n & req_valid & feat_ic & feat_wide & (cur_lvl == 2'd3))
        |-> !is_undef);

    // R6
    syndrome_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_trap ? (syn_class == SYND_CLASS) : (syn_class == '0 && trap_lvl == 2'd0));

    // R8
    target_not_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_trap |-> (trap_lvl >= $past(cur_lvl)) && (trap_lvl != 2'd0));
endmodule

// File: tb/sreg_access_resolver_tb.sv
`timescale 1ns/1ps
module sreg_access_resolver_tb;
    // Flag positions of the stimulus word.
    localparam logic [13:0] FA = 14'h0001, FB = 14'h0002, E1 = 14'h0004,
        E2 = 14'h0008, E3 = 14'h0010, L2ON = 14'h0020, TALL = 14'h0040,
        TFIQ = 14'h0080, TIRQ = 14'h0100, RIRQ = 14'h0200, RFIQ = 14'h0400,
        L3P = 14'h0800, PE = 14'h1000, PL = 14'h2000;
    localparam logic [13:0] CL = FA | FB | E1 | E2 | E3 | L3P;
    localparam logic [13:0] RB = RIRQ | RFIQ;
    // Expected kind: 1 undefined, 2 trap, 3 perform.
    localparam logic [1:0] XU = 2'd1, XT = 2'd2, XP = 2'd3;

    typedef struct packed {
        logic [3:0]  req;   // requirement number
        logic [1:0]  lvl;
        logic [13:0] f;
        logic [1:0]  kind;
        logic [1:0]  tl;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VT [NV] = '{
        '{4'd1, 2'd0, CL,                       XU, 2'd0}, // R1 level 0
        '{4'd1, 2'd1, CL & ~FB,                 XU, 2'd0}, // R1 feature missing
        '{4'd1, 2'd2, CL & ~FA,                 XU, 2'd0}, // R1 feature missing
        '{4'd2, 2'd1, CL,                       XP, 2'd0}, // R2 clean perform
        '{4'd2, 2'd1, (CL & ~E1) | RB | PE,     XU, 2'd0}, // R2 early undef wins
        '{4'd2, 2'd1, (CL & ~E1) | L2ON | TALL, XT, 2'd1}, // R2 enable before hyp
        '{4'd2, 2'd1, CL | L2ON | TALL | TFIQ,  XT, 2'd2}, // R2 common trap
        '{4'd2, 2'd1, CL | L2ON | TIRQ,         XT, 2'd2}, // R2 irq override
        '{4'd2, 2'd1, CL | TALL | TFIQ | TIRQ,  XP, 2'd0}, // R2 hyp needs level 2
        '{4'd3, 2'd1, CL | RB,                  XT, 2'd3}, // R3 routing trap
        '{4'd3, 2'd1, CL | RB | PL,             XU, 2'd0}, // R3 late undef
        '{4'd3, 2'd1, (CL & ~L3P) | RB | PE,    XP, 2'd0}, // R3 no level 3
        '{4'd3, 2'd1, CL | RIRQ | PE,           XP, 2'd0}, // R3 one routing bit
        '{4'd3, 2'd1, CL | L2ON | TFIQ | RB | PL, XT, 2'd2}, // R3 hyp before late
        '{4'd4, 2'd2, CL,                       XP, 2'd0}, // R4 clean perform
        '{4'd4, 2'd2, (CL & ~E2) | RB | PE,     XU, 2'd0}, // R4 early undef wins
        '{4'd4, 2'd2, (CL & ~E2) | RB,          XT, 2'd2}, // R4 own enable
        '{4'd4, 2'd2, CL | RB,                  XT, 2'd3}, // R4 routing trap
        '{4'd4, 2'd2, CL | RB | PL,             XU, 2'd0}, // R4 late undef
        '{4'd4, 2'd2, (CL & ~E1) | L2ON | TALL | TFIQ | TIRQ, XP, 2'd0}, // R4 ignored bits
        '{4'd5, 2'd3, CL & ~E3,                 XT, 2'd3}, // R5 own enable
        '{4'd5, 2'd3, (CL & ~E1 & ~E2) | RB | PE | PL | L2ON | TALL, XP, 2'd0}, // R5 ignored
        '{4'd5, 2'd3, (CL & ~E3) | RB | PE,     XT, 2'd3}  // R5 enable trap
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] cur_lvl = '0;
    logic [13:0] fl = '0;
    logic is_undef, is_trap, wr_en;
    logic [1:0] trap_lvl;
    logic [5:0] syn_class;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sreg_access_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_lvl(cur_lvl),
        .feat_ic(fl[0]), .feat_wide(fl[1]), .ifc_en_l1(fl[2]), .ifc_en_l2(fl[3]),
        .ifc_en_l3(fl[4]), .l2_active(fl[5]), .hyp_trap_all(fl[6]),
        .hyp_fiq_ovr(fl[7]), .hyp_irq_ovr(fl[8]), .top_route_irq(fl[9]),
        .top_route_fiq(fl[10]), .l3_present(fl[11]), .pol_undef_early(fl[12]),
        .pol_undef_late(fl[13]), .is_undef(is_undef), .is_trap(is_trap),
        .trap_lvl(trap_lvl), .syn_class(syn_class), .wr_en(wr_en)
    );

    // Compare all outputs against an expected kind (0 = idle) and level.
    task automatic check(input string tag, input logic [1:0] kind, input logic [1:0] tl);
        logic [10:0] act, exp;
        act = {is_undef, is_trap, wr_en, trap_lvl, syn_class};
        exp = {kind == XU, kind == XT, kind == XP,
               (kind == XT) ? tl : 2'd0, (kind == XT) ? 6'h18 : 6'h00};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset state", 2'd0, 2'd0);
        // Request present during reset must not reach the outputs (R9).
        req_valid = 1'b1; cur_lvl = 2'd3; fl = CL & ~E3;
        @(negedge clk);
        check("R9 request under reset", 2'd0, 2'd0);
        rst_n = 1'b1;
        // Vector table, back to back: each result checked one edge later.
        for (int i = 0; i < NV; i++) begin
            cur_lvl = VT[i].lvl; fl = VT[i].f; req_valid = 1'b1;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VT[i].req, i), VT[i].kind, VT[i].tl);
        end
        // Idle: no request gives all-zero result (R7).
        req_valid = 1'b0; cur_lvl = 2'd1; fl = CL & ~E1;
        @(negedge clk);
        check("R7 idle", 2'd0, 2'd0);
        // Single request then idle: result lasts exactly one cycle (R9).
        req_valid = 1'b1; cur_lvl = 2'd2; fl = CL | RB;
        @(negedge clk);
        check("R8 trap above level 2", XT, 2'd3);
        req_valid = 1'b0;
        @(negedge clk);
        check("R9 result drops after one cycle", 2'd0, 2'd0);
        // Mid-run reset clears a pending trap (R9).
        req_valid = 1'b1; cur_lvl = 2'd1; fl = CL & ~E1;
        @(negedge clk);
        check("R6 trap to level 1", XT, 2'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid-run reset", 2'd0, 2'd0);
        rst_n = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 2000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule